// File: doc/BRIEF.md
# Strobed Bidirectional Peripheral Port

This block is one bidirectional parallel port with a full handshake on both directions. The peripheral side has one shared set of data lines and five control lines. The block holds an output register for data written by the CPU and a separate input latch for data strobed in by the peripheral. Both can hold valid data at the same time.

The port drives the shared lines only while the peripheral holds acknowledge low. At all other times the lines float, even if output data is pending. The output direction and the input direction each have their own interrupt enable flag. Both flags are written through a bit set/reset command that addresses one bit of the control port. Each direction raises its own interrupt request, and the two requests share one interrupt line. The block also produces the five status bits of the control-port image that belong to this port.

All peripheral inputs are sampled on `clk`. Edges of strobe and acknowledge are found by comparing each sample with the one before it, so the response appears after the edge that samples the change.

Top module: `bsp_port`

## Requirements
- R1: After reset, `obf_n`=1, `ibf`=0, `intr`=0, both enables are 0, and the output register and input latch are 0.
- R2: A cycle with `cpu_wr`=1 loads `cpu_wdata` into the output register, drives `obf_n` low and clears the output-side interrupt.
- R3: `pad_out` always shows the output register. `pad_oe` is 1 exactly while `ack_n` is 0.
- R4: A sampled falling edge of `ack_n` sets `obf_n` back to 1.
- R5: In every cycle where `stb_n` is sampled low, the input latch captures the port data and `ibf` goes to 1. `cpu_rdata` always returns the input latch.
- R6: A bit set/reset command (`bsr_we`=1) with `bsr_sel`=6 writes `bsr_val` into the output enable, and `bsr_sel`=4 writes it into the input enable. Any other `bsr_sel` code changes neither enable.
- R7: A sampled rising edge of `ack_n` raises the output-side interrupt only when the output enable is 1. A sampled rising edge of `stb_n` raises the input-side interrupt only when the input enable is 1.
- R8: A cycle with `cpu_rd`=1 clears `ibf` and the input-side interrupt. The input latch keeps its value.
- R9: `intr` is the OR of the two interrupt sources. Clearing an enable drops the interrupt held by that side.
- R10: `status_hi` bits 4..0 are, in order: `obf_n`, output enable, `ibf`, input enable, `intr`.
- R11: When `stb_n` and `ack_n` are both low, the port drives the output register, and the input latch captures that driven value, not `pad_in`.
- R12: A write in the same cycle as an acknowledge falling edge leaves `obf_n` low. A capture in the same cycle as a read leaves `ibf` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_wr | input | 1 | CPU write to the port data register |
| cpu_wdata | input | DW | CPU write data |
| cpu_rd | input | 1 | CPU read of the port data register |
| cpu_rdata | output | DW | Input latch contents |
| bsr_we | input | 1 | Bit set/reset command valid |
| bsr_sel | input | 3 | Control-port bit number addressed by the command |
| bsr_val | input | 1 | Value to write (1 sets the bit, 0 clears it) |
| pad_in | input | DW | Data seen on the shared peripheral lines |
| pad_out | output | DW | Data offered to the shared peripheral lines |
| pad_oe | output | 1 | Output enable for the shared lines |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |
| status_hi | output | 5 | Status image bits 7..3 |

## Verification
The bench builds the port with its default 8-bit data width and the default enable bit codes 6 and 4. With those values, every status bit position and every bit set/reset code named in the requirements can be checked directly against literal values. Several sequences put two events in one cycle: strobe together with acknowledge, a read together with a write, a write together with an acknowledge edge, and a capture together with a read. These sequences expose the priority rules and the rule that the input latch captures the port's own driven data.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int unsigned SEL_W = 3;

  typedef struct packed {
    logic obf_n;
    logic en_out;
    logic ibf;
    logic en_in;
    logic irq;
  } bsp_stat_t;
endpackage

// File: rtl/bsp_rst_sync.sv
module bsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_q = sh_q[STAGES-1];
endmodule

// File: rtl/bsp_edge.sv
module bsp_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign rise[i] = !prev_q[i] &&  sig[i];
    assign fall[i] =  prev_q[i] && !sig[i];
  end
endmodule

// File: rtl/bsp_out_side.sv
module bsp_out_side
  import bsp_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter logic [SEL_W-1:0] EN_CODE = 3'd6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic             ack_fall,
  input  logic             ack_rise,
  input  logic             bsr_we,
  input  logic [SEL_W-1:0] bsr_sel,
  input  logic             bsr_val,
  output logic [DW-1:0]    data_q,
  output logic             obf_n,
  output logic             irq,
  output logic             en
);
  logic obf_n_q, obf_n_d;
  logic irq_q, irq_d;
  logic en_q, en_d;
  logic en_wr;

  assign en_wr = bsr_we && (bsr_sel == EN_CODE);

  always_comb begin
    en_d = en_wr ? bsr_val : en_q;

    obf_n_d = obf_n_q;
    if (ack_fall) obf_n_d = 1'b1;
    if (wr)       obf_n_d = 1'b0;

    irq_d = irq_q;
    if (ack_rise && en_q) irq_d = 1'b1;
    if (wr)               irq_d = 1'b0;
    if (!en_d)            irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_n_q <= 1'b1;
      irq_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      obf_n_q <= obf_n_d;
      irq_q   <= irq_d;
      en_q    <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (wr) data_q <= wdata;
  end

  assign obf_n = obf_n_q;
  assign irq   = irq_q;
  assign en    = en_q;
endmodule

// File: rtl/bsp_in_side.sv
module bsp_in_side
  import bsp_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter logic [SEL_W-1:0] EN_CODE = 3'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             capture,
  input  logic [DW-1:0]    cap_data,
  input  logic             stb_rise,
  input  logic             bsr_we,
  input  logic [SEL_W-1:0] bsr_sel,
  input  logic             bsr_val,
  output logic [DW-1:0]    latch_q,
  output logic             ibf,
  output logic             irq,
  output logic             en
);
  logic ibf_q, ibf_d;
  logic irq_q, irq_d;
  logic en_q, en_d;
  logic en_wr;

  assign en_wr = bsr_we && (bsr_sel == EN_CODE);

  always_comb begin
    en_d = en_wr ? bsr_val : en_q;

    ibf_d = ibf_q;
    if (rd)      ibf_d = 1'b0;
    if (capture) ibf_d = 1'b1;

    irq_d = irq_q;
    if (rd)                irq_d = 1'b0;
    if (stb_rise && en_q)  irq_d = 1'b1;
    if (!en_d)             irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      irq_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      ibf_q <= ibf_d;
      irq_q <= irq_d;
      en_q  <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (capture) latch_q <= cap_data;
  end

  assign ibf = ibf_q;
  assign irq = irq_q;
  assign en  = en_q;
endmodule

// File: rtl/bsp_port.sv
module bsp_port
  import bsp_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned RST_STAGES  = 2,
  parameter logic [SEL_W-1:0] OUT_EN_CODE = 3'd6,
  parameter logic [SEL_W-1:0] IN_EN_CODE  = 3'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_rd,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             bsr_we,
  input  logic [SEL_W-1:0] bsr_sel,
  input  logic             bsr_val,
  input  logic [DW-1:0]    pad_in,
  output logic [DW-1:0]    pad_out,
  output logic             pad_oe,
  input  logic             stb_n,
  input  logic             ack_n,
  output logic             obf_n,
  output logic             ibf,
  output logic             intr,
  output logic [4:0]       status_hi
);
  localparam int unsigned IDX_ACK = 0;
  localparam int unsigned IDX_STB = 1;

  logic          rst_n_q;
  logic [1:0]    rise, fall;
  logic [DW-1:0] out_q;
  logic          out_irq, in_irq, en_out, en_in;
  logic [DW-1:0] cap_data;
  bsp_stat_t     stat;

  bsp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_q (rst_n_q)
  );

  bsp_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n_q),
    .sig   ({stb_n, ack_n}),
    .rise  (rise),
    .fall  (fall)
  );

  bsp_out_side #(.DW(DW), .EN_CODE(OUT_EN_CODE)) u_out (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .wr       (cpu_wr),
    .wdata    (cpu_wdata),
    .ack_fall (fall[IDX_ACK]),
    .ack_rise (rise[IDX_ACK]),
    .bsr_we   (bsr_we),
    .bsr_sel  (bsr_sel),
    .bsr_val  (bsr_val),
    .data_q   (out_q),
    .obf_n    (obf_n),
    .irq      (out_irq),
    .en       (en_out)
  );

  // While the port drives the lines, the value on them is the output register.
  assign pad_oe   = !ack_n;
  assign cap_data = pad_oe ? out_q : pad_in;

  bsp_in_side #(.DW(DW), .EN_CODE(IN_EN_CODE)) u_in (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .rd       (cpu_rd),
    .capture  (!stb_n),
    .cap_data (cap_data),
    .stb_rise (rise[IDX_STB]),
    .bsr_we   (bsr_we),
    .bsr_sel  (bsr_sel),
    .bsr_val  (bsr_val),
    .latch_q  (cpu_rdata),
    .ibf      (ibf),
    .irq      (in_irq),
    .en       (en_in)
  );

  assign pad_out = out_q;
  assign intr    = out_irq || in_irq;

  always_comb begin
    stat.obf_n  = obf_n;
    stat.en_out = en_out;
    stat.ibf    = ibf;
    stat.en_in  = en_in;
    stat.irq    = intr;
  end
  assign status_hi = stat;
endmodule

// File: rtl/bsp_port_chk.sv
module bsp_port_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_wdata,
  input logic          cpu_rd,
  input logic [DW-1:0] cpu_rdata,
  input logic          bsr_we,
  input logic [2:0]    bsr_sel,
  input logic          bsr_val,
  input logic [DW-1:0] pad_in,
  input logic [DW-1:0] pad_out,
  input logic          stb_n,
  input logic          ack_n,
  input logic          obf_n,
  input logic          ibf,
  input logic          intr,
  input logic [4:0]    status_hi
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (!obf_n && pad_out == $past(cpu_wdata)));

  a_r4_ack_fall_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $fell(ack_n) && !cpu_wr) |=> obf_n);

  a_r5_strobe_captures: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && ack_n) |=> (ibf && cpu_rdata == $past(pad_in)));

  a_r8_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && stb_n) |=> !ibf);

  a_r6_enable_out_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_we && bsr_sel == 3'd6 && bsr_val) |=> status_hi[3]);

  a_r7_stb_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $rose(stb_n) && status_hi[1] && !(bsr_we && bsr_sel == 3'd4 && !bsr_val)) |=> intr);

  a_r9_no_source_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_hi[3] && !status_hi[1]) |-> !intr);
endmodule

bind bsp_port bsp_port_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_q),
  .cpu_wr    (cpu_wr),
  .cpu_wdata (cpu_wdata),
  .cpu_rd    (cpu_rd),
  .cpu_rdata (cpu_rdata),
  .bsr_we    (bsr_we),
  .bsr_sel   (bsr_sel),
  .bsr_val   (bsr_val),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .stb_n     (stb_n),
  .ack_n     (ack_n),
  .obf_n     (obf_n),
  .ibf       (ibf),
  .intr      (intr),
  .status_hi (status_hi)
);

// File: tb/tb_bsp_port.sv
module tb_bsp_port;
  logic       clk;
  logic       rst_n;
  logic       cpu_wr, cpu_rd, bsr_we, bsr_val, stb_n, ack_n;
  logic [7:0] cpu_wdata, pad_in;
  logic [2:0] bsr_sel;
  logic [7:0] cpu_rdata, pad_out;
  logic       pad_oe, obf_n, ibf, intr;
  logic [4:0] status_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic       obf_n;
    logic       ibf;
    logic       intr;
    logic       oe;
    logic [7:0] rdata;
    logic [7:0] pout;
    logic [4:0] st;
  } exp_t;

  exp_t q[$];

  bsp_port dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .bsr_we(bsr_we), .bsr_sel(bsr_sel),
    .bsr_val(bsr_val), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .stb_n(stb_n), .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf), .intr(intr),
    .status_hi(status_hi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: compare each pushed expectation after the edge it belongs to.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (obf_n !== e.obf_n || ibf !== e.ibf || intr !== e.intr || pad_oe !== e.oe ||
          cpu_rdata !== e.rdata || pad_out !== e.pout || status_hi !== e.st) begin
        errors++;
        $display("FAIL %s: got obf_n=%b ibf=%b intr=%b oe=%b rdata=%h pout=%h st=%b, exp obf_n=%b ibf=%b intr=%b oe=%b rdata=%h pout=%h st=%b",
                 e.tag, obf_n, ibf, intr, pad_oe, cpu_rdata, pad_out, status_hi,
                 e.obf_n, e.ibf, e.intr, e.oe, e.rdata, e.pout, e.st);
      end
    end
  end

  task automatic idle();
    cpu_wr = 0; cpu_rd = 0; bsr_we = 0; bsr_val = 0; bsr_sel = 3'd0;
  endtask

  // Driver: inputs are already set at a falling edge; push expectation, run one cycle.
  task automatic tick(input string tag, input logic eo, input logic ei, input logic eq,
                      input logic eoe, input logic [7:0] er, input logic [7:0] ep,
                      input logic [4:0] es);
    exp_t e;
    e.tag = tag; e.obf_n = eo; e.ibf = ei; e.intr = eq; e.oe = eoe;
    e.rdata = er; e.pout = ep; e.st = es;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic bsr(input logic [2:0] sel, input logic v);
    bsr_we = 1; bsr_sel = sel; bsr_val = v;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1; cpu_wdata = d;
  endtask

  initial begin
    #300000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); cpu_wdata = 0; pad_in = 0; stb_n = 1; ack_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    tick("R1 reset state", 1,0,0,0, 8'h00, 8'h00, 5'b10000);
    wr(8'hA5);
    tick("R2 write fills", 0,0,0,0, 8'h00, 8'hA5, 5'b00000);
    bsr(3'd6, 1);
    tick("R6 R10 set out enable", 0,0,0,0, 8'h00, 8'hA5, 5'b01000);
    ack_n = 0;
    tick("R3 R4 ack low drives", 1,0,0,1, 8'h00, 8'hA5, 5'b11000);
    ack_n = 1;
    tick("R7 ack rise irq", 1,0,1,0, 8'h00, 8'hA5, 5'b11001);
    wr(8'h3C);
    tick("R2 write clears irq", 0,0,0,0, 8'h00, 8'h3C, 5'b01000);
    bsr(3'd6, 0);
    tick("R6 clear out enable", 0,0,0,0, 8'h00, 8'h3C, 5'b00000);
    ack_n = 0;
    tick("R4 ack fall", 1,0,0,1, 8'h00, 8'h3C, 5'b10000);
    ack_n = 1;
    tick("R7 masked ack rise", 1,0,0,0, 8'h00, 8'h3C, 5'b10000);
    wr(8'h77);
    tick("R2 second write", 0,0,0,0, 8'h00, 8'h77, 5'b00000);
    bsr(3'd4, 1);
    tick("R6 set in enable", 0,0,0,0, 8'h00, 8'h77, 5'b00010);
    stb_n = 0; pad_in = 8'h5A;
    tick("R5 strobe capture", 0,1,0,0, 8'h5A, 8'h77, 5'b00110);
    stb_n = 1; pad_in = 8'h00;
    tick("R7 strobe rise irq", 0,1,1,0, 8'h5A, 8'h77, 5'b00111);
    cpu_rd = 1;
    tick("R8 read clears", 0,0,0,0, 8'h5A, 8'h77, 5'b00010);
    bsr(3'd2, 1);
    tick("R6 other code ignored", 0,0,0,0, 8'h5A, 8'h77, 5'b00010);
    bsr(3'd7, 1);
    tick("R6 code 7 ignored", 0,0,0,0, 8'h5A, 8'h77, 5'b00010);
    ack_n = 0; stb_n = 0; pad_in = 8'hFF;
    tick("R11 capture driven value", 1,1,0,1, 8'h77, 8'h77, 5'b10110);
    ack_n = 1; stb_n = 1; pad_in = 8'h00;
    tick("R7 both rise", 1,1,1,0, 8'h77, 8'h77, 5'b10111);
    cpu_rd = 1; wr(8'h11);
    tick("R8 R2 read with write", 0,0,0,0, 8'h77, 8'h11, 5'b00010);
    ack_n = 0; wr(8'h22);
    tick("R12 write beats ack fall", 0,0,0,1, 8'h77, 8'h22, 5'b00010);
    ack_n = 1;
    tick("R7 masked after write", 0,0,0,0, 8'h77, 8'h22, 5'b00010);
    bsr(3'd6, 1);
    tick("R6 out enable again", 0,0,0,0, 8'h77, 8'h22, 5'b01010);
    ack_n = 0;
    tick("R4 ack fall again", 1,0,0,1, 8'h77, 8'h22, 5'b11010);
    ack_n = 1;
    tick("R7 out irq", 1,0,1,0, 8'h77, 8'h22, 5'b11011);
    stb_n = 0; pad_in = 8'h42; cpu_rd = 1;
    tick("R12 capture beats read", 1,1,1,0, 8'h42, 8'h22, 5'b11111);
    stb_n = 1; pad_in = 8'h00;
    tick("R9 both sources", 1,1,1,0, 8'h42, 8'h22, 5'b11111);
    cpu_rd = 1;
    tick("R9 OR keeps out irq", 1,0,1,0, 8'h42, 8'h22, 5'b11011);
    bsr(3'd6, 0);
    tick("R9 disable drops out irq", 1,0,0,0, 8'h42, 8'h22, 5'b10010);
    stb_n = 0; pad_in = 8'h99;
    tick("R5 capture pad", 1,1,0,0, 8'h99, 8'h22, 5'b10110);
    stb_n = 1; pad_in = 8'h00;
    tick("R7 in irq", 1,1,1,0, 8'h99, 8'h22, 5'b10111);
    bsr(3'd4, 0);
    tick("R9 disable drops in irq", 1,1,0,0, 8'h99, 8'h22, 5'b10100);

    @(posedge clk); #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule